// File: doc/BRIEF.md
# Panel Supply Sequencing and Discharge Supervisor

This block is the control core of a gate-driver power stage for a display panel. It watches four digitized comparator flags: the high supply is above its upper (turn-on) threshold, the high supply is below its lower (turn-off) threshold, the panel discharge-sense input has dropped, and the die is over temperature. From these flags it decides how the drive stage behaves:

- the channels are held at their negative rail;
- the clock channels follow their logic inputs;
- every output, discharge outputs included, is driven to the positive rail;
- everything goes high impedance.

Each flag passes through a synchronizer and a glitch filter. A four-state machine then acts on the filtered flags. Its states are off, running, discharging and thermal shutdown. Both fault states are sticky. The only way out of either is for the supply to fall below the lower threshold. The output stage reads the commands in this order of precedence: tri-state first, then force-high, then power-good. When power-good is set and neither of the other two is set, the clock channels follow their inputs.

Top module: `panel_supply_supervisor`

## Requirements
- R1: After reset, and whenever the supply has not yet crossed the upper threshold, `pwr_good`, `force_high` and `tri_all` are 0 and every `dis_cmd` bit is 0 (0 = negative rail, 1 = positive rail).
- R2: When the upper-threshold flag asserts while discharge-sense is high, the block enters the running state: `pwr_good`=1, `force_high`=0, `tri_all`=0, `dis_cmd`=all 0.
- R3: `pwr_good` stays 1 when the upper-threshold flag drops while the lower-threshold flag is still clear. It drops to 0 only when the lower-threshold flag asserts.
- R4: A discharge-sense low while running sets `force_high`=1 and `dis_cmd`=all 1. This stays latched after discharge-sense returns high.
- R5: If discharge-sense is already low when the upper threshold is crossed, the block goes straight to `force_high`=1 with `dis_cmd`=all 1.
- R6: The discharge state is left only when the lower-threshold flag asserts. Crossing the upper threshold again does not clear it. On exit, all outputs return to the R1 values.
- R7: An over-temperature flag sets `tri_all`=1 with `force_high`=0 and `dis_cmd`=all 0. This holds even from the discharge state or if discharge-sense later falls, and it stays latched after the flag clears.
- R8: Thermal shutdown is left only when the lower-threshold flag asserts. The block then returns to the R1 values and can power up again through R2.
- R9: A flag change that lasts fewer than 4 clock cycles after the two-flop synchronizer changes no output. A change held for at least 4 cycles is accepted.
- R10: `force_high` and `tri_all` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_above_rise | input | 1 | Comparator: supply above the upper threshold (asynchronous) |
| sup_below_fall | input | 1 | Comparator: supply below the lower threshold (asynchronous) |
| dsense_low | input | 1 | Comparator: discharge-sense input below its trip level (asynchronous) |
| over_temp | input | 1 | Comparator: die over temperature (asynchronous) |
| pwr_good | output | 1 | Supply in its good window (hysteretic) |
| force_high | output | 1 | Drive every output to the positive rail |
| tri_all | output | 1 | Put every output in high impedance |
| dis_cmd | output | NDIS | Discharge output rail select, 1 = positive rail |

## Verification
The checker assumes that the two supply flags are never asserted together, since the upper threshold lies above the lower one. The stimulus respects this: it clears the lower-threshold flag before raising the upper one, and drops the upper flag before raising the lower one. Apart from the one deliberate short pulse, every flag change is held well beyond the filter window, so each transition is taken through the filter exactly once. The sticky properties rest on the lower-threshold flag being the only path back to the off state, and the directed cases try to disturb each fault state with every other flag before releasing it.

// File: rtl/supv_pkg.sv
package supv_pkg;
  localparam int NFLAG   = 4;
  localparam int FLG_RISE = 0;
  localparam int FLG_FALL = 1;
  localparam int FLG_DSL  = 2;
  localparam int FLG_OT   = 3;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_RUN   = 2'd1,
    ST_DISCH = 2'd2,
    ST_THERM = 2'd3
  } supv_state_t;
endpackage

// File: rtl/supv_flag_filter.sv
module supv_flag_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic clean
);
  localparam int CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       agree_cnt;
  logic                   settled;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
  end

  assign settled = sync_q[SYNC_STAGES-1];

  // Accept a new level only after it has differed for FILT_LEN cycles.
  always_ff @(posedge clk) begin
    if (rst) begin
      clean     <= 1'b0;
      agree_cnt <= '0;
    end else if (settled == clean) begin
      agree_cnt <= '0;
    end else if (agree_cnt == CNT_W'(FILT_LEN - 1)) begin
      clean     <= settled;
      agree_cnt <= '0;
    end else begin
      agree_cnt <= agree_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/supv_flag_bank.sv
module supv_flag_bank #(
  parameter int NF          = 4,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] raw_flags,
  output logic [NF-1:0] clean_flags
);
  for (genvar g = 0; g < NF; g++) begin : g_flt
    supv_flag_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_flt (
      .clk  (clk),
      .rst  (rst),
      .raw  (raw_flags[g]),
      .clean(clean_flags[g])
    );
  end
endmodule

// File: rtl/supv_fsm.sv
module supv_fsm
  import supv_pkg::*;
#(
  parameter int NDIS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] flags,
  output logic             pwr_good,
  output logic             force_high,
  output logic             tri_all,
  output logic [NDIS-1:0]  dis_cmd
);
  supv_state_t state_q, state_d;
  logic        sup_ok_q, sup_ok_d;
  logic        f_rise, f_fall, f_dsl, f_ot;

  assign f_rise = flags[FLG_RISE];
  assign f_fall = flags[FLG_FALL];
  assign f_dsl  = flags[FLG_DSL];
  assign f_ot   = flags[FLG_OT];

  // Hysteretic supply window: set on upper crossing, cleared on lower.
  always_comb begin
    sup_ok_d = sup_ok_q;
    if (f_fall)      sup_ok_d = 1'b0;
    else if (f_rise) sup_ok_d = 1'b1;
  end

  // Release by the lower threshold wins, then thermal, then discharge.
  always_comb begin
    state_d = state_q;
    if (f_fall) begin
      state_d = ST_OFF;
    end else if (f_ot) begin
      state_d = ST_THERM;
    end else begin
      unique case (state_q)
        ST_OFF:   if (f_rise) state_d = f_dsl ? ST_DISCH : ST_RUN;
        ST_RUN:   if (f_dsl)  state_d = ST_DISCH;
        ST_DISCH: state_d = ST_DISCH;
        ST_THERM: state_d = ST_THERM;
        default:  state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_OFF;
      sup_ok_q   <= 1'b0;
      pwr_good   <= 1'b0;
      force_high <= 1'b0;
      tri_all    <= 1'b0;
      dis_cmd    <= '0;
    end else begin
      state_q    <= state_d;
      sup_ok_q   <= sup_ok_d;
      pwr_good   <= sup_ok_d;
      force_high <= (state_d == ST_DISCH);
      tri_all    <= (state_d == ST_THERM);
      dis_cmd    <= {NDIS{state_d == ST_DISCH}};
    end
  end
endmodule

// File: rtl/panel_supply_supervisor.sv
module panel_supply_supervisor
  import supv_pkg::*;
#(
  parameter int NDIS        = 2,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sup_above_rise,
  input  logic            sup_below_fall,
  input  logic            dsense_low,
  input  logic            over_temp,
  output logic            pwr_good,
  output logic            force_high,
  output logic            tri_all,
  output logic [NDIS-1:0] dis_cmd
);
  logic [NFLAG-1:0] raw_flags, clean_flags;

  always_comb begin
    raw_flags           = '0;
    raw_flags[FLG_RISE] = sup_above_rise;
    raw_flags[FLG_FALL] = sup_below_fall;
    raw_flags[FLG_DSL]  = dsense_low;
    raw_flags[FLG_OT]   = over_temp;
  end

  supv_flag_bank #(
    .NF         (NFLAG),
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN)
  ) u_bank (
    .clk        (clk),
    .rst        (rst),
    .raw_flags  (raw_flags),
    .clean_flags(clean_flags)
  );

  supv_fsm #(
    .NDIS(NDIS)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .flags     (clean_flags),
    .pwr_good  (pwr_good),
    .force_high(force_high),
    .tri_all   (tri_all),
    .dis_cmd   (dis_cmd)
  );
endmodule

// File: rtl/panel_supply_supervisor_chk.sv
module panel_supply_supervisor_chk #(
  parameter int NDIS = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            pwr_good,
  input logic            force_high,
  input logic            tri_all,
  input logic [NDIS-1:0] dis_cmd
);
  assert_hi_and_z_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(force_high && tri_all));

  assert_dis_follows_force_R4: assert property (@(posedge clk) disable iff (rst)
    force_high |-> (dis_cmd == {NDIS{1'b1}}));

  assert_dis_low_otherwise_R7: assert property (@(posedge clk) disable iff (rst)
    !force_high |-> (dis_cmd == '0));

  assert_disch_exit_by_fall_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(force_high) |-> (!pwr_good || tri_all));

  assert_therm_exit_by_fall_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(tri_all) |-> !pwr_good);

  assert_disch_needs_supply_R1: assert property (@(posedge clk) disable iff (rst)
    (!pwr_good && !tri_all) |-> !force_high);
endmodule

bind panel_supply_supervisor panel_supply_supervisor_chk #(.NDIS(NDIS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pwr_good  (pwr_good),
  .force_high(force_high),
  .tri_all   (tri_all),
  .dis_cmd   (dis_cmd)
);

// File: tb/panel_supply_supervisor_bench.sv
module panel_supply_supervisor_bench;
  localparam int NDIS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sup_above_rise = 1'b0;
  logic sup_below_fall = 1'b1;
  logic dsense_low = 1'b0;
  logic over_temp = 1'b0;
  logic pwr_good, force_high, tri_all;
  logic [NDIS-1:0] dis_cmd;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  panel_supply_supervisor #(.NDIS(NDIS)) u_panel_supply_supervisor (
    .clk(clk), .rst(rst),
    .sup_above_rise(sup_above_rise), .sup_below_fall(sup_below_fall),
    .dsense_low(dsense_low), .over_temp(over_temp),
    .pwr_good(pwr_good), .force_high(force_high),
    .tri_all(tri_all), .dis_cmd(dis_cmd)
  );

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Expected vector is {pwr_good, force_high, tri_all, dis_cmd}.
  task automatic expect_out(input string req, input logic pg, input logic fh,
                            input logic tz, input logic [NDIS-1:0] dc);
    logic [NDIS+2:0] act, exp;
    act = {pwr_good, force_high, tri_all, dis_cmd};
    exp = {pg, fh, tz, dc};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic power_up();
    sup_below_fall = 1'b0; settle(12);
    sup_above_rise = 1'b1; settle(12);
  endtask

  task automatic power_down();
    sup_above_rise = 1'b0; settle(12);
    sup_below_fall = 1'b1; settle(12);
  endtask

  task automatic t_reset();
    settle(3);
    expect_out("R1 reset", 0, 0, 0, '0);
    rst = 1'b0; settle(12);
    expect_out("R1 off after reset", 0, 0, 0, '0);
    sup_below_fall = 1'b0; settle(12);
    expect_out("R1 band without upper crossing", 0, 0, 0, '0);
    sup_below_fall = 1'b1; settle(12);
  endtask

  task automatic t_run_and_hysteresis();
    power_up();
    expect_out("R2 running", 1, 0, 0, '0);
    sup_above_rise = 1'b0; settle(12);
    expect_out("R3 held in band", 1, 0, 0, '0);
    sup_below_fall = 1'b1; settle(12);
    expect_out("R3 released below lower", 0, 0, 0, '0);
  endtask

  task automatic t_glitch_and_discharge();
    power_up();
    dsense_low = 1'b1; settle(3); dsense_low = 1'b0; settle(12);
    expect_out("R9 short pulse ignored", 1, 0, 0, '0);
    dsense_low = 1'b1; settle(8); dsense_low = 1'b0; settle(12);
    expect_out("R4 discharge latched", 1, 1, 0, '1);
    sup_above_rise = 1'b0; settle(12);
    sup_above_rise = 1'b1; settle(12);
    expect_out("R6 upper crossing does not clear", 1, 1, 0, '1);
    power_down();
    expect_out("R6 cleared by lower threshold", 0, 0, 0, '0);
  endtask

  task automatic t_sense_low_at_powerup();
    dsense_low = 1'b1; settle(12);
    power_up();
    expect_out("R5 direct discharge", 1, 1, 0, '1);
    dsense_low = 1'b0;
    power_down();
    expect_out("R6 release after direct entry", 0, 0, 0, '0);
  endtask

  task automatic t_thermal();
    power_up();
    over_temp = 1'b1; settle(12);
    expect_out("R7 thermal high-z", 1, 0, 1, '0);
    over_temp = 1'b0; settle(12);
    expect_out("R7 thermal latched", 1, 0, 1, '0);
    dsense_low = 1'b1; settle(12);
    expect_out("R7 thermal over discharge", 1, 0, 1, '0);
    dsense_low = 1'b0; settle(12);
    power_down();
    expect_out("R8 thermal cleared", 0, 0, 0, '0);
    power_up();
    expect_out("R8 restart after thermal", 1, 0, 0, '0);
    dsense_low = 1'b1; settle(12);
    dsense_low = 1'b0;
    over_temp = 1'b1; settle(12);
    over_temp = 1'b0; settle(12);
    expect_out("R7 thermal overrides discharge", 1, 0, 1, '0);
    power_down();
    expect_out("R8 cleared from discharge-entered thermal", 0, 0, 0, '0);
  endtask

  initial begin
    t_reset();
    t_run_and_hysteresis();
    t_glitch_and_discharge();
    t_sense_low_at_powerup();
    t_thermal();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=<100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule